// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key FIFO

This block scans a key matrix one row at a time. It drives a set of scan lines and samples eight return lines. A key that is seen closed is debounced. The block then applies one of two multi-key policies, selected by a mode input. Each accepted press becomes an 8-bit key code, which goes into an eight-entry first-in first-out queue. A processor reads that queue through a small strobe-based register port.

The scan lines work in one of two styles, also set by a mode input. In encoded style they carry a binary row number meant for an external 3-to-8 decoder, which gives an 8x8 matrix. In decoded style they carry one active line per row, which gives a 4x8 matrix. The scan rate comes from the `scan_tick` input. On each tick the return lines of the current row are latched. A row controller (`SC_IDLE`, `SC_WALK`) then visits the eight keys of that row on eight consecutive clocks, one key per clock, and advances to the next row.

**N-key rollover.** Every key has its own state machine with four states: `K_OPEN`, `K_SEEN1`, `K_SEEN2` and `K_HELD`.
- `K_OPEN` moves to `K_SEEN1` when the key is seen closed.
- `K_SEEN1` moves to `K_SEEN2` if the key is closed at its next visit, and back to `K_OPEN` otherwise.
- `K_SEEN2` pushes the code and moves to `K_HELD` if the key is still closed at its next visit. Otherwise it returns to `K_OPEN`.
- `K_HELD` returns to `K_OPEN` at the first visit that finds the key open.

**Two-key lockout.** A single machine with four states (`LK_IDLE`, `LK_DEBOUNCE`, `LK_HELD`, `LK_LOCKED`) judges each completed scan by two things: the number of closed keys in that scan, and the last closed code.
- One closed key moves `LK_IDLE` to `LK_DEBOUNCE`.
- Two or more closed keys move `LK_IDLE` or `LK_DEBOUNCE` to `LK_LOCKED`.
- `LK_DEBOUNCE` pushes the code after two further scans that show the same single key, then moves to `LK_HELD`. A different single key restarts the debounce. No closed key returns it to `LK_IDLE`.
- `LK_HELD` returns to `LK_IDLE` after a scan in which the accepted key is open.
- `LK_LOCKED` moves to `LK_DEBOUNCE` when exactly one key remains closed, and to `LK_IDLE` when none does.

Top module: `keyscan_top`

## Requirements
- R1: With `mode_decoded`=0, `scan_out[2:0]` carries the row number and `scan_out[3]` stays 0. All eight rows 0..7 appear in turn, and the row is 0 after reset.
- R2: With `mode_decoded`=1, `scan_out` is one-hot with bit n meaning row n, and it starts at 4'b0001. Only rows 0..3 are scanned, so keys in rows 4..7 never produce a code.
- R3: A key code holds shift at bit 7, control at bit 6, the scan row in bits 5:3 and the return-line index in bits 2:0. Shift and control are sampled when the code is pushed.
- R4: With `mode_nkro`=1, a key enters the FIFO only if it is closed at three consecutive visits (two full scans after first being seen). A press that lasts exactly one scan is dropped. Keys closed together each give an entry, and keys in one row enter in rising column order.
- R5: The FIFO keeps up to 8 codes in arrival order. A data read (`cs`=1, `rd`=1, `cmd_sel`=0) returns the oldest code on `rdata` and removes it. The status read (`cmd_sel`=1) shows the entry count in bits 3:0.
- R6: `irq` is 1 exactly while the FIFO holds at least one code. It falls in the cycle after the last code is read.
- R7: A push into a full FIFO drops the code and sets status bit 6 (overrun).
- R8: A data read of an empty FIFO sets status bit 5 (underrun).
- R9: A command write (`cs`=1, `wr`=1, `cmd_sel`=1) of 8'hC0 empties the FIFO and clears both error bits. Data writes and any other command value change nothing.
- R10: A key that stays closed gives one entry only. It can give another only after it has been seen open.
- R11: With `mode_nkro`=0:
  - A lone key is accepted after two further scans that show it alone.
  - While it is held, other keys are ignored.
  - Two keys closed within the debounce interval yield nothing until one is released. The remaining key is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle pulse that samples the current row; at least RET_W+2 cycles apart |
| mode_decoded | input | 1 | 1: one-hot 4-row scan; 0: binary 8-row scan |
| mode_nkro | input | 1 | 1: N-key rollover; 0: two-key lockout |
| ret_in | input | 8 | Return lines, 1 = key closed |
| shift_in | input | 1 | Shift key input |
| ctrl_in | input | 1 | Control key input |
| scan_out | output | 4 | Scan lines |
| cs | input | 1 | Select |
| rd | input | 1 | One-cycle read strobe |
| wr | input | 1 | One-cycle write strobe |
| cmd_sel | input | 1 | 1: command/status path; 0: FIFO data path |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Status byte or oldest FIFO code |
| irq | output | 1 | Interrupt request, high while the FIFO is not empty |

## Verification
The matrix model presses a single key and holds it past acceptance, which separates debounce from repeated entry. A press of exactly one scan length separates a transient closure from a real press. Two keys in the same row show the column ordering. In two-key lockout, a second key pressed during a hold separates lockout from rollover, and a simultaneous pair followed by a release separates rejection from acceptance of the survivor. A full row plus one extra key drives the FIFO past its capacity, and a read of the empty FIFO produces underrun. The decoded style is checked both for one-hot scan lines and for keys it must not reach.

// File: rtl/kbs_pkg.sv
package kbs_pkg;

    typedef enum logic [0:0] {
        SC_IDLE,
        SC_WALK
    } scan_st_e;

    typedef enum logic [1:0] {
        K_OPEN,
        K_SEEN1,
        K_SEEN2,
        K_HELD
    } key_st_e;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_DEBOUNCE,
        LK_HELD,
        LK_LOCKED
    } lock_st_e;

    localparam logic [7:0] CMD_CLEAR  = 8'hC0;
    localparam int         ST_UNR_BIT = 5;
    localparam int         ST_OVR_BIT = 6;

endpackage

// File: rtl/kbs_scan_ctrl.sv
module kbs_scan_ctrl
    import kbs_pkg::*;
#(
    parameter int RET_W     = 8,
    parameter int ROW_W     = 3,
    parameter int DEC_LINES = 4,
    localparam int COL_W    = $clog2(RET_W),
    localparam int KEY_W    = ROW_W + COL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_tick,
    input  logic                 mode_decoded,
    input  logic [RET_W-1:0]     ret_in,
    output logic [DEC_LINES-1:0] scan_out,
    output logic                 key_valid,
    output logic                 key_closed,
    output logic [KEY_W-1:0]     key_code,
    output logic                 scan_end
);

    localparam logic [ROW_W-1:0] LAST_ENC = ROW_W'((1 << ROW_W) - 1);
    localparam logic [ROW_W-1:0] LAST_DEC = ROW_W'(DEC_LINES - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(RET_W - 1);

    scan_st_e           state_q, state_d;
    logic [ROW_W-1:0]   row_q, row_d;
    logic [COL_W-1:0]   col_q, col_d;
    logic [RET_W-1:0]   ret_q, ret_d;
    logic               last_row;

    assign last_row = (row_q == (mode_decoded ? LAST_DEC : LAST_ENC));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            ret_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            col_q   <= col_d;
            ret_q   <= ret_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        col_d   = col_q;
        ret_d   = ret_q;
        unique case (state_q)
            SC_IDLE: begin
                if (scan_tick) begin
                    ret_d   = ret_in;
                    col_d   = '0;
                    state_d = SC_WALK;
                end
            end
            SC_WALK: begin
                col_d = col_q + 1'b1;
                if (col_q == LAST_COL) begin
                    state_d = SC_IDLE;
                    row_d   = last_row ? '0 : row_q + 1'b1;
                end
            end
            default: state_d = SC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        key_valid  = (state_q == SC_WALK);
        key_closed = ret_q[col_q];
        key_code   = {row_q, col_q};
        scan_end   = key_valid && (col_q == LAST_COL) && last_row;
        if (mode_decoded) begin
            scan_out = DEC_LINES'(1) << row_q;
        end else begin
            scan_out = {{(DEC_LINES-ROW_W){1'b0}}, row_q};
        end
    end

endmodule

// File: rtl/kbs_nkro.sv
module kbs_nkro
    import kbs_pkg::*;
#(
    parameter int KEY_W   = 6,
    localparam int NKEYS  = 1 << KEY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             key_valid,
    input  logic             key_closed,
    input  logic [KEY_W-1:0] key_code,
    output logic             push
);

    key_st_e st_q [NKEYS];
    key_st_e cur_st, st_d;
    logic    visit;

    assign visit  = enable && key_valid;
    assign cur_st = st_q[key_code];

    // state register: one entry per key
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NKEYS; i++) begin
                st_q[i] <= K_OPEN;
            end
        end else if (visit) begin
            st_q[key_code] <= st_d;
        end
    end

    // next state for the key being visited
    always_comb begin
        st_d = cur_st;
        unique case (cur_st)
            K_OPEN:  st_d = key_closed ? K_SEEN1 : K_OPEN;
            K_SEEN1: st_d = key_closed ? K_SEEN2 : K_OPEN;
            K_SEEN2: st_d = key_closed ? K_HELD  : K_OPEN;
            K_HELD:  st_d = key_closed ? K_HELD  : K_OPEN;
            default: st_d = K_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        push = visit && key_closed && (cur_st == K_SEEN2);
    end

endmodule

// File: rtl/kbs_lockout.sv
module kbs_lockout
    import kbs_pkg::*;
#(
    parameter int KEY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             key_valid,
    input  logic             key_closed,
    input  logic [KEY_W-1:0] key_code,
    input  logic             scan_end,
    output logic             push,
    output logic [KEY_W-1:0] push_code
);

    lock_st_e          state_q, state_d;
    logic [KEY_W-1:0]  cand_q, cand_d;
    logic              deb_q, deb_d;
    logic [1:0]        acc_n_q;
    logic [KEY_W-1:0]  acc_code_q;
    logic              acc_cand_q;

    logic              visit, hit, judge;
    logic [1:0]        n_now;
    logic [KEY_W-1:0]  code_now;
    logic              cand_now;

    assign visit    = enable && key_valid;
    assign hit      = visit && key_closed;
    assign judge    = visit && scan_end;
    assign n_now    = (acc_n_q == 2'd2) ? 2'd2 : acc_n_q + {1'b0, hit};
    assign code_now = hit ? key_code : acc_code_q;
    assign cand_now = acc_cand_q || (hit && (key_code == cand_q));

    // state register and per-scan tally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LK_IDLE;
            cand_q     <= '0;
            deb_q      <= 1'b0;
            acc_n_q    <= '0;
            acc_code_q <= '0;
            acc_cand_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cand_q  <= cand_d;
            deb_q   <= deb_d;
            if (visit) begin
                if (scan_end) begin
                    acc_n_q    <= '0;
                    acc_code_q <= '0;
                    acc_cand_q <= 1'b0;
                end else begin
                    acc_n_q    <= n_now;
                    acc_code_q <= code_now;
                    acc_cand_q <= cand_now;
                end
            end
        end
    end

    // next state, judged once per completed scan
    always_comb begin
        state_d = state_q;
        cand_d  = cand_q;
        deb_d   = deb_q;
        if (judge) begin
            unique case (state_q)
                LK_IDLE: begin
                    if (n_now == 2'd1) begin
                        state_d = LK_DEBOUNCE;
                        cand_d  = code_now;
                        deb_d   = 1'b0;
                    end else if (n_now == 2'd2) begin
                        state_d = LK_LOCKED;
                    end
                end
                LK_DEBOUNCE: begin
                    if (n_now == 2'd0) begin
                        state_d = LK_IDLE;
                    end else if (n_now == 2'd2) begin
                        state_d = LK_LOCKED;
                    end else if (code_now != cand_q) begin
                        cand_d = code_now;
                        deb_d  = 1'b0;
                    end else if (deb_q) begin
                        state_d = LK_HELD;
                    end else begin
                        deb_d = 1'b1;
                    end
                end
                LK_HELD: begin
                    if (!cand_now) begin
                        state_d = LK_IDLE;
                    end
                end
                LK_LOCKED: begin
                    if (n_now == 2'd0) begin
                        state_d = LK_IDLE;
                    end else if (n_now == 2'd1) begin
                        state_d = LK_DEBOUNCE;
                        cand_d  = code_now;
                        deb_d   = 1'b0;
                    end
                end
                default: state_d = LK_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        push      = judge && (state_q == LK_DEBOUNCE) && (n_now == 2'd1)
                    && (code_now == cand_q) && deb_q;
        push_code = cand_q;
    end

endmodule

// File: rtl/kbs_fifo.sv
module kbs_fifo #(
    parameter int W      = 8,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop_req,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             ovr,
    output logic             unr
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic             pop_ok, wr_ok;

    assign full   = (count == FULL_CNT);
    assign pop_ok = pop_req && (count != '0);
    assign wr_ok  = push && (!full || pop_ok);
    assign head   = mem[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (wr_ok && !clear) begin
            mem[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count    <= '0;
            ovr      <= 1'b0;
            unr      <= 1'b0;
        end else begin
            if (wr_ok) begin
                wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            end
            if (wr_ok && !pop_ok) begin
                count <= count + 1'b1;
            end else if (pop_ok && !wr_ok) begin
                count <= count - 1'b1;
            end
            if (push && !wr_ok) begin
                ovr <= 1'b1;
            end
            if (pop_req && (count == '0)) begin
                unr <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/keyscan_top.sv
module keyscan_top
    import kbs_pkg::*;
#(
    parameter int RET_W      = 8,
    parameter int ROW_W      = 3,
    parameter int DEC_LINES  = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_tick,
    input  logic                 mode_decoded,
    input  logic                 mode_nkro,
    input  logic [RET_W-1:0]     ret_in,
    input  logic                 shift_in,
    input  logic                 ctrl_in,
    output logic [DEC_LINES-1:0] scan_out,
    input  logic                 cs,
    input  logic                 rd,
    input  logic                 wr,
    input  logic                 cmd_sel,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic                 irq
);

    localparam int COL_W  = $clog2(RET_W);
    localparam int KEY_W  = ROW_W + COL_W;
    localparam int DATA_W = KEY_W + 2;
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

    logic             key_valid, key_closed, scan_end;
    logic [KEY_W-1:0] key_code;
    logic             nk_push, lk_push;
    logic [KEY_W-1:0] lk_code;

    logic             fifo_push, fifo_pop, fifo_full, clr_cmd;
    logic [DATA_W-1:0] fifo_wdata, fifo_head;
    logic [CNT_W-1:0] fifo_count;
    logic             ovr_flag, unr_flag;
    logic [7:0]       status;

    kbs_scan_ctrl #(
        .RET_W     (RET_W),
        .ROW_W     (ROW_W),
        .DEC_LINES (DEC_LINES)
    ) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_tick    (scan_tick),
        .mode_decoded (mode_decoded),
        .ret_in       (ret_in),
        .scan_out     (scan_out),
        .key_valid    (key_valid),
        .key_closed   (key_closed),
        .key_code     (key_code),
        .scan_end     (scan_end)
    );

    kbs_nkro #(.KEY_W(KEY_W)) u_nkro (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (mode_nkro),
        .key_valid  (key_valid),
        .key_closed (key_closed),
        .key_code   (key_code),
        .push       (nk_push)
    );

    kbs_lockout #(.KEY_W(KEY_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (!mode_nkro),
        .key_valid  (key_valid),
        .key_closed (key_closed),
        .key_code   (key_code),
        .scan_end   (scan_end),
        .push       (lk_push),
        .push_code  (lk_code)
    );

    assign fifo_push  = mode_nkro ? nk_push : lk_push;
    assign fifo_wdata = {shift_in, ctrl_in, (mode_nkro ? key_code : lk_code)};
    assign fifo_pop   = cs && rd && !cmd_sel;
    assign clr_cmd    = cs && wr && cmd_sel && (wdata == CMD_CLEAR);

    kbs_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clr_cmd),
        .push      (fifo_push),
        .push_data (fifo_wdata),
        .pop_req   (fifo_pop),
        .head      (fifo_head),
        .count     (fifo_count),
        .full      (fifo_full),
        .ovr       (ovr_flag),
        .unr       (unr_flag)
    );

    always_comb begin
        status                = '0;
        status[CNT_W-1:0]     = fifo_count;
        status[ST_UNR_BIT]    = unr_flag;
        status[ST_OVR_BIT]    = ovr_flag;
        rdata                 = cmd_sel ? status : 8'(fifo_head);
        irq                   = (fifo_count != '0);
    end

endmodule

// File: rtl/kbs_checker.sv
module kbs_checker #(
    parameter int CNT_W  = 4,
    parameter int DEPTH  = 8,
    parameter int SCAN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_decoded,
    input logic [SCAN_W-1:0] scan_out,
    input logic              irq,
    input logic              clr_cmd,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              fifo_full,
    input logic              fifo_push,
    input logic              fifo_pop,
    input logic              ovr_flag,
    input logic              unr_flag
);

    assert_encoded_top_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_decoded |-> !scan_out[SCAN_W-1]);

    assert_decoded_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_decoded |-> $onehot(scan_out));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    assert_push_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && !fifo_full && !fifo_pop && !clr_cmd)
        |=> (fifo_count == $past(fifo_count) + 1'b1));

    assert_irq_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && (fifo_count == CNT_W'(1)) && !fifo_push && !clr_cmd) |=> !irq);

    assert_overrun_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && fifo_full && !fifo_pop && !clr_cmd) |=> ovr_flag);

    assert_underrun_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && (fifo_count == '0) && !clr_cmd) |=> unr_flag);

    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (fifo_count == '0 && !irq && !ovr_flag && !unr_flag));

endmodule

bind keyscan_top kbs_checker #(
    .CNT_W  (CNT_W),
    .DEPTH  (FIFO_DEPTH),
    .SCAN_W (DEC_LINES)
) u_kbs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_decoded (mode_decoded),
    .scan_out     (scan_out),
    .irq          (irq),
    .clr_cmd      (clr_cmd),
    .fifo_count   (fifo_count),
    .fifo_full    (fifo_full),
    .fifo_push    (fifo_push),
    .fifo_pop     (fifo_pop),
    .ovr_flag     (ovr_flag),
    .unr_flag     (unr_flag)
);

// File: tb/keyscan_top_bench.sv
`timescale 1ns/1ps
module keyscan_top_bench;

    localparam int TICK_GAP = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_tick = 1'b0;
    logic       mode_decoded = 1'b0;
    logic       mode_nkro = 1'b1;
    logic [7:0] ret_in;
    logic       shift_in = 1'b0;
    logic       ctrl_in = 1'b0;
    logic [3:0] scan_out;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, cmd_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    logic [7:0] keys [8];
    logic [2:0] ridx;
    int         checks = 0;
    int         failures = 0;

    always #2 clk = ~clk;

    keyscan_top u_keyscan_top (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick),
        .mode_decoded(mode_decoded), .mode_nkro(mode_nkro),
        .ret_in(ret_in), .shift_in(shift_in), .ctrl_in(ctrl_in),
        .scan_out(scan_out), .cs(cs), .rd(rd), .wr(wr),
        .cmd_sel(cmd_sel), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // key matrix model
    always_comb begin
        ridx = 3'd0;
        if (mode_decoded) begin
            for (int i = 0; i < 4; i++) if (scan_out[i]) ridx = 3'(i);
        end else begin
            ridx = scan_out[2:0];
        end
        ret_in = keys[ridx];
    end

    initial begin
        forever begin
            repeat (TICK_GAP - 1) @(negedge clk);
            scan_tick = 1'b1;
            @(negedge clk);
            scan_tick = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic release_all();
        for (int r = 0; r < 8; r++) keys[r] = 8'h00;
    endtask

    task automatic do_reset(input logic dec, input logic nk);
        @(negedge clk);
        rst_n = 1'b0;
        mode_decoded = dec;
        mode_nkro = nk;
        shift_in = 1'b0;
        ctrl_in = 1'b0;
        release_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_scans(input int n);
        repeat (n * (mode_decoded ? 4 : 8) * TICK_GAP) @(negedge clk);
    endtask

    task automatic cpu_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; cmd_sel = sel;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; cmd_sel = 1'b0;
    endtask

    task automatic cpu_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; cmd_sel = sel; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; cmd_sel = 1'b0; wdata = 8'h00;
    endtask

    task automatic t_reset_and_encoded_scan();
        logic [7:0] d;
        logic [7:0] seen;
        logic       high_bit;
        do_reset(1'b0, 1'b1);
        chk("R1 scan_out after reset", {4'h0, scan_out}, 8'h00);
        chk("R6 irq after reset", {7'h0, irq}, 8'h00);
        cpu_read(1'b1, d);
        chk("R5 status after reset", d, 8'h00);
        seen = 8'h00;
        high_bit = 1'b0;
        for (int c = 0; c < 8 * TICK_GAP * 2; c++) begin
            @(negedge clk);
            if (scan_out[3]) high_bit = 1'b1;
            seen[scan_out[2:0]] = 1'b1;
        end
        chk("R1 rows visited", seen, 8'hFF);
        chk("R1 scan_out bit3", {7'h0, high_bit}, 8'h00);
    endtask

    task automatic t_nkro_single_held();
        logic [7:0] d;
        do_reset(1'b0, 1'b1);
        shift_in = 1'b1;
        keys[5][3] = 1'b1;
        wait_scans(4);
        cpu_read(1'b1, d);
        chk("R5 count after one press", d, 8'h01);
        chk("R6 irq with data", {7'h0, irq}, 8'h01);
        cpu_read(1'b0, d);
        chk("R3 code shift row5 col3", d, 8'hAB);
        @(negedge clk);
        chk("R6 irq after last read", {7'h0, irq}, 8'h00);
        wait_scans(4);
        cpu_read(1'b1, d);
        chk("R10 held key no repeat", d, 8'h00);
        keys[5][3] = 1'b0;
        wait_scans(2);
        keys[5][3] = 1'b1;
        wait_scans(4);
        cpu_read(1'b1, d);
        chk("R10 re-press after release", d, 8'h01);
        cpu_read(1'b0, d);
        release_all();
        shift_in = 1'b0;
    endtask

    task automatic t_nkro_short_press();
        logic [7:0] d;
        do_reset(1'b0, 1'b1);
        keys[2][6] = 1'b1;
        wait_scans(1);
        keys[2][6] = 1'b0;
        wait_scans(4);
        cpu_read(1'b1, d);
        chk("R4 one-scan press dropped", d, 8'h00);
    endtask

    task automatic t_nkro_same_row();
        logic [7:0] d;
        do_reset(1'b0, 1'b1);
        ctrl_in = 1'b1;
        keys[4][2] = 1'b1;
        keys[4][6] = 1'b1;
        wait_scans(4);
        cpu_read(1'b1, d);
        chk("R4 two keys two entries", d, 8'h02);
        cpu_read(1'b0, d);
        chk("R4 first entry col2 with ctrl", d, 8'h62);
        cpu_read(1'b0, d);
        chk("R5 second entry col6", d, 8'h66);
        release_all();
        ctrl_in = 1'b0;
    endtask

    task automatic t_commands();
        logic [7:0] d;
        do_reset(1'b0, 1'b1);
        keys[1][1] = 1'b1;
        wait_scans(4);
        cpu_write(1'b0, 8'hFF);
        cpu_write(1'b1, 8'h00);
        cpu_write(1'b1, 8'hC1);
        cpu_read(1'b1, d);
        chk("R9 other writes ignored", d, 8'h01);
        cpu_write(1'b1, 8'hC0);
        cpu_read(1'b1, d);
        chk("R9 clear empties", d, 8'h00);
        chk("R9 irq after clear", {7'h0, irq}, 8'h00);
        release_all();
        cpu_read(1'b0, d);
        cpu_read(1'b1, d);
        chk("R8 underrun flag", d, 8'h20);
        cpu_write(1'b1, 8'hC0);
        cpu_read(1'b1, d);
        chk("R9 clear drops underrun", d, 8'h00);
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        do_reset(1'b0, 1'b1);
        keys[1] = 8'hFF;
        keys[2][0] = 1'b1;
        wait_scans(4);
        cpu_read(1'b1, d);
        chk("R7 overrun with full count", d, 8'h48);
        chk("R6 irq when full", {7'h0, irq}, 8'h01);
        cpu_write(1'b1, 8'hC0);
        cpu_read(1'b1, d);
        chk("R9 clear after overrun", d, 8'h00);
        release_all();
    endtask

    task automatic t_lockout();
        logic [7:0] d;
        do_reset(1'b0, 1'b0);
        keys[3][4] = 1'b1;
        wait_scans(5);
        cpu_read(1'b1, d);
        chk("R11 lone key accepted", d, 8'h01);
        cpu_read(1'b0, d);
        chk("R11 lone key code", d, 8'h1C);
        keys[6][1] = 1'b1;
        wait_scans(5);
        cpu_read(1'b1, d);
        chk("R11 second key ignored while held", d, 8'h00);
        release_all();
        wait_scans(2);
        keys[0][5] = 1'b1;
        keys[7][2] = 1'b1;
        wait_scans(5);
        cpu_read(1'b1, d);
        chk("R11 simultaneous pair rejected", d, 8'h00);
        keys[0][5] = 1'b0;
        wait_scans(5);
        cpu_read(1'b1, d);
        chk("R11 survivor accepted", d, 8'h01);
        cpu_read(1'b0, d);
        chk("R11 survivor code", d, 8'h3A);
        release_all();
    endtask

    task automatic t_decoded();
        logic [7:0] d;
        logic [3:0] seen;
        logic       bad;
        do_reset(1'b1, 1'b1);
        chk("R2 scan_out after reset", {4'h0, scan_out}, 8'h01);
        seen = 4'h0;
        bad = 1'b0;
        for (int c = 0; c < 4 * TICK_GAP * 2; c++) begin
            @(negedge clk);
            if (!$onehot(scan_out)) bad = 1'b1;
            seen = seen | scan_out;
        end
        chk("R2 one-hot lines", {7'h0, bad}, 8'h00);
        chk("R2 four rows visited", {4'h0, seen}, 8'h0F);
        keys[3][5] = 1'b1;
        keys[5][0] = 1'b1;
        wait_scans(4);
        cpu_read(1'b1, d);
        chk("R2 only reachable row counted", d, 8'h01);
        cpu_read(1'b0, d);
        chk("R2 decoded code row3 col5", d, 8'h1D);
        release_all();
    endtask

    initial begin
        release_all();
        t_reset_and_encoded_scan();
        t_nkro_single_held();
        t_nkro_short_press();
        t_nkro_same_row();
        t_commands();
        t_overrun();
        t_lockout();
        t_decoded();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule